// File: doc/BRIEF.md
# Reload / Capture / Toggle Timer Channel

This block is a single 16-bit timer channel. It can run in one of three modes. In reload mode it counts up and, after the all-ones value, restarts from a programmable start value. In capture mode it counts freely and latches the running count when a falling edge arrives on an input pin. Toggle mode works like reload mode, and in addition it inverts an output pin on every wrap, which gives a square wave with a 50% duty cycle.

The count advances on a tick. The tick can come from every system clock, from one system clock in twelve, or from every eighth rising edge of an asynchronous external oscillator. That oscillator is first synchronized into the system clock domain. One register holds both the reload value and the captured value.

Software reaches a control register, the count and the reload/capture register through a small word-wide register port. An interrupt line reports the wrap and capture flags when they are enabled.

An internal state machine picks the operating state from the run bit and the mode field. The four states are STOP, RELOAD, CAPTURE and TOGGLE. The transitions between them are:
- **start**: leaves STOP for the state the mode field names, when run is 1 and the mode field is 00, 01 or 10.
- **halt**: goes from any state to STOP when run is 0 or the mode field is 11.
- **retarget**: moves directly between running states when the mode field changes while running.

Top module: `reload_capture_timer`

## Requirements
- R1: After reset, CTRL, COUNT and RCAP read 0, and `tog_out` and `irq` are 0.
- R2: Reload mode (CTRL[2:1]=00):
  - Each tick adds 1 to COUNT.
  - A tick while COUNT is 0xFFFF loads COUNT from RCAP and sets the wrap flag CTRL[8].
- R3: Capture mode (CTRL[2:1]=01):
  - A synchronized falling edge on `cap_pin` copies COUNT into RCAP and sets the capture flag CTRL[9].
  - COUNT keeps counting.
  - A tick at 0xFFFF wraps COUNT to 0 and sets CTRL[8].
- R4: Outside capture mode, falling edges on `cap_pin` leave RCAP and CTRL[9] unchanged.
- R5: Toggle mode (CTRL[2:1]=10):
  - COUNT behaves as in reload mode.
  - `tog_out` inverts on every wrap, so its period is twice the reload interval and its duty cycle is 50%.
  - CTRL[10] reads back the level of `tog_out`.
- R6: The clock select field CTRL[4:3] sets the tick rate:
  - 00: one tick per system clock.
  - 01: one tick per 12 system clocks.
  - 10: one tick per 8 rising edges of `ext_clk`.
  - 11: no ticks.
- R7: Run control:
  - With CTRL[0]=0 or CTRL[2:1]=11, COUNT holds.
  - After a control write that starts the timer, the first increment happens on the second clock edge after the write edge.
- R8: `irq` = (CTRL[8] and CTRL[5]) or (CTRL[9] and CTRL[6]).
- R9: Flag writes:
  - Writing 0 to CTRL[8] or CTRL[9] clears that flag.
  - Writing 1 leaves the flag as it is.
  - A flag set by hardware in the same cycle as a clear wins.
- R10: Register map and write priority:
  - `addr` 0 selects CTRL, 1 selects COUNT, 2 selects RCAP, and 3 reads 0.
  - A software write to COUNT takes priority over a tick and suppresses that tick's wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register (combinational) |
| ext_clk | input | 1 | External oscillator, asynchronous to `clk` |
| cap_pin | input | 1 | Capture input, asynchronous; idles high |
| tog_out | output | 1 | Square-wave output in toggle mode |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state, such as the machine stuck in STOP or sitting in the wrong running state, shows up within two clock edges of the control write. COUNT either fails to move or fails to wrap to the expected value, and RCAP changes when it should not.

Counter faults in the prescaler or the external-clock divider stay hidden from single reads. They appear only as a count difference over a window of many ticks, so the tick rates are checked with 120-cycle and 640-cycle windows.

A bad capture synchronizer or edge detector changes the latched value by a cycle or more. It therefore shows on the RCAP read that follows the edge by three clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_RELOAD  = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_TOGGLE  = 2'd3
    } tmr_state_e;

    // mode field codes
    localparam logic [1:0] MODE_RELOAD  = 2'b00;
    localparam logic [1:0] MODE_CAPTURE = 2'b01;
    localparam logic [1:0] MODE_TOGGLE  = 2'b10;

    // clock select codes
    localparam logic [1:0] CS_SYS   = 2'b00;
    localparam logic [1:0] CS_DIVSY = 2'b01;
    localparam logic [1:0] CS_EXT   = 2'b10;

    // register addresses
    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_RCAP  = 2'd2;

    // control register bit positions
    localparam int B_RUN  = 0;
    localparam int B_MODE = 1;
    localparam int B_CS   = 3;
    localparam int B_OIE  = 5;
    localparam int B_CIE  = 6;
    localparam int B_OVF  = 8;
    localparam int B_CAP  = 9;
    localparam int B_TOG  = 10;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV_SYS     = 12,
    parameter int DIV_EXT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       ext_clk,
    output logic       tick
);
    import tmr_pkg::*;

    localparam int SW = (DIV_SYS > 1) ? $clog2(DIV_SYS) : 1;
    localparam int EW = (DIV_EXT > 1) ? $clog2(DIV_EXT) : 1;
    localparam logic [SW-1:0] SYS_LAST = SW'(DIV_SYS - 1);
    localparam logic [EW-1:0] EXT_LAST = EW'(DIV_EXT - 1);

    logic [SW-1:0]          sys_cnt;
    logic [EW-1:0]          ext_cnt;
    logic [SYNC_STAGES-1:0] ext_sync;
    logic                   ext_prev;
    logic                   ext_rise;
    logic                   ext_tick;

    // free-running system-clock prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sys_cnt <= '0;
        else if (sys_cnt == SYS_LAST) sys_cnt <= '0;
        else                       sys_cnt <= sys_cnt + SW'(1);
    end

    // synchronizer chain for the external oscillator
    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ext_sync <= '0;
                else        ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_clk};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ext_sync <= '0;
                else        ext_sync <= ext_clk;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_sync[SYNC_STAGES-1];
    end

    assign ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_cnt <= '0;
        else if (ext_rise) begin
            if (ext_cnt == EXT_LAST) ext_cnt <= '0;
            else                     ext_cnt <= ext_cnt + EW'(1);
        end
    end

    assign ext_tick = ext_rise && (ext_cnt == EXT_LAST);

    always_comb begin
        tick = 1'b0;
        unique case (sel)
            CS_SYS:   tick = 1'b1;
            CS_DIVSY: tick = (sys_cnt == SYS_LAST);
            CS_EXT:   tick = ext_tick;
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [1:0]          mode,
    output tmr_pkg::tmr_state_e state,
    output logic                cnt_en,
    output logic                use_reload,
    output logic                cap_en,
    output logic                tog_en
);
    import tmr_pkg::*;

    tmr_state_e nxt;

    // next-state: start / halt / retarget
    always_comb begin
        nxt = ST_STOP;
        if (run) begin
            unique case (mode)
                MODE_RELOAD:  nxt = ST_RELOAD;
                MODE_CAPTURE: nxt = ST_CAPTURE;
                MODE_TOGGLE:  nxt = ST_TOGGLE;
                default:      nxt = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= nxt;
    end

    always_comb begin
        cnt_en     = 1'b0;
        use_reload = 1'b0;
        cap_en     = 1'b0;
        tog_en     = 1'b0;
        unique case (state)
            ST_STOP: ;
            ST_RELOAD: begin
                cnt_en     = 1'b1;
                use_reload = 1'b1;
            end
            ST_CAPTURE: begin
                cnt_en = 1'b1;
                cap_en = 1'b1;
            end
            ST_TOGGLE: begin
                cnt_en     = 1'b1;
                use_reload = 1'b1;
                tog_en     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer #(
    parameter int WIDTH       = 16,
    parameter int DIV_SYS     = 12,
    parameter int DIV_EXT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic             ext_clk,
    input  logic             cap_pin,
    output logic             tog_out,
    output logic             irq
);
    import tmr_pkg::*;

    localparam logic [WIDTH-1:0] CNT_MAX = '1;
    localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

    // control fields
    logic       run_q;
    logic [1:0] mode_q;
    logic [1:0] cs_q;
    logic       oie_q;
    logic       cie_q;
    logic       ovf_flag;
    logic       cap_flag;
    logic       tog_q;

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] rcap_q;

    tmr_state_e state;
    logic cnt_en, use_reload, cap_en, tog_en;
    logic tick, fall;
    logic ctrl_wr, cnt_wr, rcap_wr;
    logic ovf_evt, cap_evt;
    logic [WIDTH-1:0] ctrl_view;

    tmr_tick_gen #(
        .DIV_SYS     (DIV_SYS),
        .DIV_EXT     (DIV_EXT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cs_q),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    tmr_fall_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .fall  (fall)
    );

    tmr_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .mode       (mode_q),
        .state      (state),
        .cnt_en     (cnt_en),
        .use_reload (use_reload),
        .cap_en     (cap_en),
        .tog_en     (tog_en)
    );

    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign cnt_wr  = wr_en && (addr == A_COUNT);
    assign rcap_wr = wr_en && (addr == A_RCAP);

    assign ovf_evt = cnt_en && tick && (count_q == CNT_MAX) && !cnt_wr;
    assign cap_evt = cap_en && fall;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_RELOAD;
            cs_q   <= CS_SYS;
            oie_q  <= 1'b0;
            cie_q  <= 1'b0;
        end else if (ctrl_wr) begin
            run_q  <= wr_data[B_RUN];
            mode_q <= wr_data[B_MODE +: 2];
            cs_q   <= wr_data[B_CS +: 2];
            oie_q  <= wr_data[B_OIE];
            cie_q  <= wr_data[B_CIE];
        end
    end

    // flags: cleared by writing 0, hardware set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            cap_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt | (ovf_flag & ~(ctrl_wr & ~wr_data[B_OVF]));
            cap_flag <= cap_evt | (cap_flag & ~(ctrl_wr & ~wr_data[B_CAP]));
        end
    end

    // count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= wr_data;
        end else if (cnt_en && tick) begin
            if (count_q == CNT_MAX) count_q <= use_reload ? rcap_q : '0;
            else                    count_q <= count_q + CNT_ONE;
        end
    end

    // reload / capture register: capture wins over a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rcap_q <= '0;
        else if (cap_evt) rcap_q <= count_q;
        else if (rcap_wr) rcap_q <= wr_data;
    end

    // square-wave output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 tog_q <= 1'b0;
        else if (tog_en && ovf_evt) tog_q <= ~tog_q;
    end

    assign tog_out = tog_q;
    assign irq     = (ovf_flag & oie_q) | (cap_flag & cie_q);

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[B_RUN]       = run_q;
        ctrl_view[B_MODE +: 2] = mode_q;
        ctrl_view[B_CS +: 2]   = cs_q;
        ctrl_view[B_OIE]       = oie_q;
        ctrl_view[B_CIE]       = cie_q;
        ctrl_view[B_OVF]       = ovf_flag;
        ctrl_view[B_CAP]       = cap_flag;
        ctrl_view[B_TOG]       = tog_q;
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_CTRL:  rd_data = ctrl_view;
            A_COUNT: rd_data = count_q;
            A_RCAP:  rd_data = rcap_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int WIDTH = 16
) (
    input logic                clk,
    input logic                rst_n,
    input tmr_pkg::tmr_state_e state,
    input logic                tick,
    input logic                cnt_wr,
    input logic                rcap_wr,
    input logic [WIDTH-1:0]    count_q,
    input logic [WIDTH-1:0]    rcap_q,
    input logic                ovf_flag,
    input logic                cap_flag,
    input logic                tog_out,
    input logic                irq
);
    import tmr_pkg::*;

    localparam logic [WIDTH-1:0] CMAX = '1;
    localparam logic [WIDTH-1:0] CONE = WIDTH'(1);

    // R2
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELOAD && tick && count_q == CMAX && !cnt_wr)
        |=> (count_q == $past(rcap_q) && ovf_flag));

    // R3
    cap_keep_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && tick && count_q != CMAX && !cnt_wr)
        |=> (count_q == $past(count_q) + CONE));

    // R4
    no_cap_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CAPTURE && !rcap_wr) |=> ($stable(rcap_q) && !$rose(cap_flag)));

    // R5
    tog_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_out) |-> $past(state == ST_TOGGLE && tick && count_q == CMAX && !cnt_wr));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !cnt_wr) |=> $stable(count_q));

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag || cap_flag));

endmodule

bind reload_capture_timer tmr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .tick     (tick),
    .cnt_wr   (cnt_wr),
    .rcap_wr  (rcap_wr),
    .count_q  (count_q),
    .rcap_q   (rcap_q),
    .ovf_flag (ovf_flag),
    .cap_flag (cap_flag),
    .tog_out  (tog_out),
    .irq      (irq)
);

// File: tb/reload_capture_timer_tb.sv
module reload_capture_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        ext_clk = 1'b0;
    logic        cap_pin = 1'b1;
    logic        tog_out;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;            // 50 MHz
    initial begin
        #5;
        forever #80 ext_clk = ~ext_clk;   // 8 system clocks per period
    end

    reload_capture_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ext_clk (ext_clk),
        .cap_pin (cap_pin),
        .tog_out (tog_out),
        .irq     (irq)
    );

    localparam logic [1:0] AC = 2'd0, AN = 2'd1, AR = 2'd2;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [15:0] ctl(input logic run, input logic [1:0] mode,
                                        input logic [1:0] cs, input logic oie,
                                        input logic cie, input logic keep);
        logic [15:0] v;
        v = 16'h0;
        v[0] = run; v[2:1] = mode; v[4:3] = cs; v[5] = oie; v[6] = cie;
        v[8] = keep; v[9] = keep;
        return v;
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        rd(AC, v); check("R1 ctrl", v, 16'h0);
        rd(AN, v); check("R1 count", v, 16'h0);
        rd(AR, v); check("R1 rcap", v, 16'h0);
        check("R1 tog_out", {15'h0, tog_out}, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_reload();
        logic [15:0] v;
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
        wr(AN, 16'hFFFD);
        wr(AR, 16'h1234);
        wr(AC, ctl(1, 2'b00, 2'b00, 1, 0, 1));
        @(negedge clk); rd(AN, v); check("R7 start latency", v, 16'hFFFD);
        @(negedge clk); rd(AN, v); check("R2 increment", v, 16'hFFFE);
        @(negedge clk); rd(AN, v); check("R2 at max", v, 16'hFFFF);
        @(negedge clk); rd(AN, v); check("R2 reload", v, 16'h1234);
        rd(AC, v); check("R2 wrap flag", {15'h0, v[8]}, 16'h1);
        check("R8 irq on wrap", {15'h0, irq}, 16'h1);
        @(negedge clk); rd(AN, v); check("R2 after reload", v, 16'h1235);
    endtask

    task automatic t_irq_flags();
        logic [15:0] v;
        wr(AC, ctl(1, 2'b00, 2'b00, 0, 0, 1));
        check("R8 irq masked", {15'h0, irq}, 16'h0);
        rd(AC, v); check("R9 write 1 keeps flag", {15'h0, v[8]}, 16'h1);
        wr(AC, ctl(0, 2'b00, 2'b00, 1, 1, 0));
        rd(AC, v); check("R9 write 0 clears", {14'h0, v[9:8]}, 16'h0);
        check("R8 irq after clear", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        rd(2'd3, v); check("R10 addr3 reads 0", v, 16'h0);
        wr(AR, 16'h0F0F);
        rd(AR, v); check("R10 rcap readback", v, 16'h0F0F);
        wr(AC, ctl(1, 2'b00, 2'b00, 0, 0, 0));
        @(negedge clk); @(negedge clk);
        wr(AN, 16'h5000);
        rd(AN, v); check("R10 count write priority", v, 16'h5000);
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
    endtask

    task automatic t_toggle();
        logic [15:0] v;
        int trans, runlen, first_at;
        logic prev;
        bit bad_len;
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
        wr(AN, 16'hFFFC);
        wr(AR, 16'hFFFC);
        wr(AC, ctl(1, 2'b10, 2'b00, 0, 0, 0));
        prev = tog_out; trans = 0; runlen = 0; first_at = 0; bad_len = 1'b0;
        for (int i = 1; i <= 48; i++) begin
            @(negedge clk);
            runlen++;
            if (tog_out !== prev) begin
                if (trans == 0) first_at = i;
                else if (runlen != 4) bad_len = 1'b1;
                trans++;
                runlen = 0;
                prev = tog_out;
            end
        end
        check("R5 toggle count", 16'(trans), 16'd11);
        check("R5 first toggle", 16'(first_at), 16'd5);
        check("R5 half period 4", {15'h0, bad_len}, 16'h0);
        rd(AC, v); check("R5 level readback", {15'h0, v[10]}, {15'h0, tog_out});
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
    endtask

    task automatic t_capture();
        logic [15:0] v, c, cnt;
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
        wr(AN, 16'h0100);
        wr(AR, 16'h0000);
        wr(AC, ctl(1, 2'b01, 2'b00, 0, 1, 0));
        repeat (3) @(negedge clk);
        cap_pin = 1'b0; addr = AN;
        @(negedge clk); @(negedge clk);
        #1; c = rd_data;
        @(negedge clk);
        rd(AR, v); check("R3 captured value", v, c);
        rd(AC, v); check("R3 capture flag", {15'h0, v[9]}, 16'h1);
        check("R8 irq on capture", {15'h0, irq}, 16'h1);
        @(negedge clk);
        rd(AN, cnt); check("R3 count keeps running", cnt, c + 16'd2);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(AN, 16'hFFFF);
        @(negedge clk);
        rd(AN, v); check("R3 wrap to zero", v, 16'h0000);
        rd(AC, v); check("R3 wrap flag", {15'h0, v[8]}, 16'h1);
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
    endtask

    task automatic t_cap_ignored();
        logic [15:0] v;
        wr(AR, 16'hABCD);
        wr(AC, ctl(1, 2'b00, 2'b00, 0, 1, 0));
        @(negedge clk);
        cap_pin = 1'b0;
        repeat (6) @(negedge clk);
        rd(AR, v); check("R4 rcap untouched", v, 16'hABCD);
        rd(AC, v); check("R4 no capture flag", {15'h0, v[9]}, 16'h0);
        check("R4 no irq", {15'h0, irq}, 16'h0);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
    endtask

    task automatic rate(input logic [1:0] cs, input int win, input logic [15:0] exp, input string req);
        logic [15:0] v0, v1;
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
        wr(AN, 16'h0000);
        wr(AC, ctl(1, 2'b00, cs, 0, 0, 0));
        @(negedge clk); @(negedge clk);
        rd(AN, v0);
        repeat (win) @(negedge clk);
        rd(AN, v1);
        check(req, v1 - v0, exp);
    endtask

    task automatic t_clksel();
        rate(2'b01, 120, 16'd10, "R6 divide by 12");
        rate(2'b10, 640, 16'd10, "R6 external divide by 8");
        rate(2'b11, 100, 16'd0,  "R6 no tick");
        rate(2'b00, 50,  16'd50, "R6 system clock");
    endtask

    task automatic t_halt();
        logic [15:0] v0, v1;
        wr(AC, ctl(1, 2'b11, 2'b00, 0, 0, 0));
        @(negedge clk);
        rd(AN, v0);
        repeat (20) @(negedge clk);
        rd(AN, v1); check("R7 mode 11 holds", v1, v0);
        wr(AC, ctl(0, 2'b00, 2'b00, 0, 0, 0));
        @(negedge clk);
        rd(AN, v0);
        repeat (20) @(negedge clk);
        rd(AN, v1); check("R7 run 0 holds", v1, v0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reload();
        t_irq_flags();
        t_regmap();
        t_toggle();
        t_capture();
        t_cap_ignored();
        t_clksel();
        t_halt();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule